// File: doc/BRIEF.md
# Counter-Compare and PWM Channel

This block is one compare channel that sits beside a free-running 16-bit counter shared by several such channels. The counter is presented as a high byte and a low byte. The channel has two ways of driving its output pin. In high-speed output mode, a 16-bit equality between the counter and the channel's compare value inverts the pin. In 8-bit PWM mode, the pin is set from a magnitude compare against the low counter byte. Every channel sees the same counter, so all PWM outputs share one frequency and differ only in duty.

Software reaches the channel through a one-cycle write port. The port selects one of three targets: the mode register, the low compare byte or the high compare byte. Writes to the two compare bytes also change the compare-enable bit. This keeps a half-written compare value from producing a match. In PWM mode the duty value is double-buffered. The high byte holds the next duty, and it is copied into the active low byte when the low counter byte wraps. A match raises a sticky flag, and the flag can request an interrupt.

Top module: `cmp_pwm_chan`

## Requirements
- R1: After an asynchronous reset the mode register and both compare bytes are zero, match_flag_o and irq_o are 0 and cex_o is 1.
- R2: A write with wr_sel_i=1 stores wr_data_i as the low compare byte and clears compare-enable (mode bit 4) from the next cycle.
- R3: A write with wr_sel_i=2 stores wr_data_i as the high compare byte and sets compare-enable from the next cycle. wr_sel_i=3 writes nothing.
- R4: A write with wr_sel_i=0 loads wr_data_i[4:0] into the mode register, which reads back on mode_o. The bits are: 4 compare-enable, 3 match, 2 toggle, 1 PWM, 0 interrupt-enable.
- R5: A match is compare-enable set with {cnt_hi_i,cnt_lo_i} equal to {high byte, low byte}. On the first cycle of a match, and only then, with the match bit set, match_flag_o rises at the next edge. A match held over many cycles sets the flag once.
- R6: match_flag_o stays set until a cycle with flag_clr_i=1. If a new flag set falls in the same cycle as the clear, the set wins.
- R7: irq_o is 1 exactly when match_flag_o and interrupt-enable are both 1.
- R8: With the match and toggle bits set and PWM inactive, cex_o inverts at the edge after the first cycle of each match.
- R9: PWM is active only when the PWM bit and compare-enable are both set. While it is active, cex_o after each edge is 1 if the cnt_lo_i sampled at that edge is greater than or equal to the duty value, and 0 otherwise.
- R10: While PWM is active, a cycle whose cnt_lo_i is 0x00 after a cycle at 0xFF copies the high byte into the low byte. That copied value is already the duty used in the 0x00 cycle. A bus write to the low byte in that same cycle takes precedence over the copy.
- R11: With PWM inactive and match and toggle not both set, cex_o holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_hi_i | input | 8 | High byte of the shared counter |
| cnt_lo_i | input | 8 | Low byte of the shared counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mode, 1 low compare, 2 high compare, 3 none |
| wr_data_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Clears the match flag |
| mode_o | output | 5 | Mode register readback |
| match_flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |
| cex_o | output | 1 | Channel output pin |

## Verification
The bench holds the counter on the matching value for several cycles, with and without a flag clear in between. A design that sets the flag at a level rather than an edge would set it again after a clear, and would toggle the pin on every cycle of the match. It issues a clear in the same cycle as a new match, which catches a design where the clear overrides the set. It sweeps the low counter byte across the duty threshold and across the 0xFF to 0x00 wrap. A design with an off-by-one in the compare would move the pin edge by one count, and a design that reloads one cycle late would hold the old duty for the whole 0x00 cycle. Random writes to the mode and compare registers check the automatic clearing and setting of compare-enable in the middle of a PWM period.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int MODE_W = 5;

  // bit 4 down to bit 0
  typedef struct packed {
    logic cmp_en;
    logic mat;
    logic tog;
    logic pwm;
    logic irq_en;
  } mode_t;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/cpc_regs.sv
module cpc_regs import cpc_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  sel_e              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              reload_i,
  output mode_t             mode_o,
  output logic [BYTE_W-1:0] cmp_lo_o,
  output logic [BYTE_W-1:0] cmp_hi_o
);
  mode_t             mode_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              wr_mode, wr_lo, wr_hi;

  assign wr_mode = wr_en_i && (wr_sel_i == SEL_MODE);
  assign wr_lo   = wr_en_i && (wr_sel_i == SEL_LO);
  assign wr_hi   = wr_en_i && (wr_sel_i == SEL_HI);

  generate
    if (BYTE_W > MODE_W) begin : g_spare
      logic unused_data_hi;
      assign unused_data_hi = ^wr_data_i[BYTE_W-1:MODE_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
    end else if (wr_lo) begin
      mode_q.cmp_en <= 1'b0;   // no match on a half-written value
    end else if (wr_hi) begin
      mode_q.cmp_en <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wr_data_i;
    end else if (reload_i) begin
      lo_q <= hi_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (wr_hi) begin
      hi_q <= wr_data_i;
    end
  end

  assign mode_o   = mode_q;
  assign cmp_lo_o = lo_q;
  assign cmp_hi_o = hi_q;
endmodule

// File: rtl/cpc_match.sv
module cpc_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  input  logic             mat_i,
  input  logic             clr_i,
  output logic             rise_o,
  output logic             flag_o
);
  logic hit, hit_q, flag_q;

  assign hit    = en_i && (cnt_i == cmp_i);
  assign rise_o = hit && !hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (rise_o && mat_i) flag_q <= 1'b1;
      else if (clr_i)      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cpc_wave.sv
module cpc_wave #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] cnt_lo_i,
  input  logic [BYTE_W-1:0] cmp_lo_i,
  input  logic [BYTE_W-1:0] cmp_hi_i,
  input  logic              pwm_act_i,
  input  logic              toggle_i,
  output logic              wrap_o,
  output logic              cex_o
);
  localparam logic [BYTE_W-1:0] TOP = {BYTE_W{1'b1}};

  logic [BYTE_W-1:0] prev_q, duty;
  logic              cex_q;

  assign wrap_o = (prev_q == TOP) && (cnt_lo_i == '0);
  // new duty already applies in the wrap cycle
  assign duty   = wrap_o ? cmp_hi_i : cmp_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cex_q  <= 1'b1;
    end else begin
      prev_q <= cnt_lo_i;
      if (pwm_act_i)     cex_q <= (cnt_lo_i >= duty);
      else if (toggle_i) cex_q <= ~cex_q;
    end
  end

  assign cex_o = cex_q;
endmodule

// File: rtl/cmp_pwm_chan.sv
module cmp_pwm_chan import cpc_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] cnt_hi_i,
  input  logic [BYTE_W-1:0] cnt_lo_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              match_flag_o,
  output logic              irq_o,
  output logic              cex_o
);
  localparam int CNT_W = 2 * BYTE_W;

  mode_t             mode;
  logic [BYTE_W-1:0] cmp_lo, cmp_hi;
  logic              pwm_act, wrap, rise, flag;

  assign pwm_act = mode.pwm && mode.cmp_en;

  cpc_regs #(.BYTE_W(BYTE_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .reload_i  (wrap && pwm_act),
    .mode_o    (mode),
    .cmp_lo_o  (cmp_lo),
    .cmp_hi_o  (cmp_hi)
  );

  cpc_match #(.CNT_W(CNT_W)) i_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  ({cnt_hi_i, cnt_lo_i}),
    .cmp_i  ({cmp_hi, cmp_lo}),
    .en_i   (mode.cmp_en),
    .mat_i  (mode.mat),
    .clr_i  (flag_clr_i),
    .rise_o (rise),
    .flag_o (flag)
  );

  cpc_wave #(.BYTE_W(BYTE_W)) i_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_lo_i  (cnt_lo_i),
    .cmp_lo_i  (cmp_lo),
    .cmp_hi_i  (cmp_hi),
    .pwm_act_i (pwm_act),
    .toggle_i  (rise && mode.mat && mode.tog),
    .wrap_o    (wrap),
    .cex_o     (cex_o)
  );

  assign mode_o       = mode;
  assign match_flag_o = flag;
  assign irq_o        = flag && mode.irq_en;
endmodule

// File: rtl/cmp_pwm_chan_chk.sv
module cmp_pwm_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic       flag_clr_i,
  input logic [4:0] mode_o,
  input logic       match_flag_o,
  input logic       irq_o,
  input logic       cex_o
);
  assert_lo_write_disables_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1) |=> !mode_o[4]);

  assert_hi_write_enables_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2) |=> mode_o[4]);

  assert_flag_needs_mat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_flag_o) |-> $past(mode_o[3]));

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !flag_clr_i) |=> match_flag_o);

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> match_flag_o);

  assert_cex_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(mode_o[4] && mode_o[1]) && !(mode_o[3] && mode_o[2])) |=> $stable(cex_o));
endmodule

bind cmp_pwm_chan cmp_pwm_chan_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .flag_clr_i   (flag_clr_i),
  .mode_o       (mode_o),
  .match_flag_o (match_flag_o),
  .irq_o        (irq_o),
  .cex_o        (cex_o)
);

// File: tb/test_cmp_pwm_chan.sv
module test_cmp_pwm_chan;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cnt_hi = '0, cnt_lo = '0, wr_data = '0;
  logic       wr_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [4:0] mode_o;
  logic       match_flag_o, irq_o, cex_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [4:0] m_mode;
  logic [7:0] m_lo, m_hi, m_prev;
  logic       m_flag, m_cex, m_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_pwm_chan i_cmp_pwm_chan (
    .clk_i(clk), .rst_ni(rst_n), .cnt_hi_i(cnt_hi), .cnt_lo_i(cnt_lo),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .flag_clr_i(flag_clr),
    .mode_o(mode_o), .match_flag_o(match_flag_o), .irq_o(irq_o), .cex_o(cex_o)
  );

  function automatic logic pwm_level(logic [7:0] c, logic [7:0] duty);
    return c >= duty;
  endfunction

  function automatic logic is_match(logic [15:0] c, logic [4:0] md, logic [7:0] hi, logic [7:0] lo);
    return md[4] && (c == {hi, lo});
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = '0; m_lo = '0; m_hi = '0; m_prev = '0;
    m_flag = 1'b0; m_cex = 1'b1; m_hit = 1'b0;
  endtask

  // one cycle: drive, advance model, clock, compare all outputs
  task automatic cyc(logic [15:0] c, logic we, logic [1:0] sel, logic [7:0] d, logic clr);
    logic pwm_act, wrap, hit, rise;
    logic [7:0] duty, n_lo;
    logic [4:0] n_mode;
    cnt_hi = c[15:8]; cnt_lo = c[7:0];
    wr_en = we; wr_sel = sel; wr_data = d; flag_clr = clr;
    pwm_act = m_mode[4] && m_mode[1];
    wrap    = (m_prev == 8'hFF) && (c[7:0] == 8'h00);
    duty    = wrap ? m_hi : m_lo;
    hit     = is_match(c, m_mode, m_hi, m_lo);
    rise    = hit && !m_hit;
    if (pwm_act)                          m_cex = pwm_level(c[7:0], duty);
    else if (rise && m_mode[3] && m_mode[2]) m_cex = ~m_cex;
    if (rise && m_mode[3]) m_flag = 1'b1;
    else if (clr)          m_flag = 1'b0;
    n_lo = (wrap && pwm_act) ? m_hi : m_lo;
    n_mode = m_mode;
    if (we) begin
      case (sel)
        2'd0: n_mode = d[4:0];
        2'd1: begin n_lo = d; n_mode[4] = 1'b0; end
        2'd2: begin m_hi = d; n_mode[4] = 1'b1; end
        default: ;
      endcase
    end
    m_lo = n_lo; m_mode = n_mode; m_hit = hit; m_prev = c[7:0];
    @(posedge clk); #1;
    wr_en = 1'b0; flag_clr = 1'b0;
    chk(mode_o == m_mode, "R4 mode readback", 16'(mode_o), 16'(m_mode));
    chk(match_flag_o == m_flag, "R5 match flag", 16'(match_flag_o), 16'(m_flag));
    chk(irq_o == (m_flag && m_mode[0]), "R7 irq", 16'(irq_o), 16'(m_flag && m_mode[0]));
    chk(cex_o == m_cex, "R9 cex", 16'(cex_o), 16'(m_cex));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] cnt;
    void'($urandom(32'd5150));
    model_reset();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    chk(mode_o == 5'd0, "R1 mode", 16'(mode_o), 16'd0);
    chk(match_flag_o == 1'b0, "R1 flag", 16'(match_flag_o), 16'd0);
    chk(irq_o == 1'b0, "R1 irq", 16'(irq_o), 16'd0);
    chk(cex_o == 1'b1, "R1 cex", 16'(cex_o), 16'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 / R2 enable handling
    cyc(16'h0000, 1, 2'd1, 8'h03, 0);
    cyc(16'h0000, 1, 2'd2, 8'h01, 0);
    chk(mode_o[4] == 1'b1, "R3 hi write sets enable", 16'(mode_o[4]), 16'd1);
    cyc(16'h0000, 1, 2'd0, 8'h1D, 0);
    cyc(16'h0000, 1, 2'd1, 8'h03, 0);
    chk(mode_o[4] == 1'b0, "R2 lo write clears enable", 16'(mode_o[4]), 16'd0);
    cyc(16'h0000, 1, 2'd2, 8'h01, 0);
    cyc(16'h0000, 1, 2'd3, 8'hFF, 0);
    chk(mode_o == 5'h1D, "R3 sel 3 writes nothing", 16'(mode_o), 16'h1D);

    // R8 toggle on match, R5 flag, R7 irq
    for (int i = 0; i < 4; i++) cyc(16'h0100 + 16'(i), 0, 2'd3, 8'h00, 0);
    chk(cex_o == 1'b0, "R8 cex toggled", 16'(cex_o), 16'd0);
    chk(match_flag_o == 1'b1, "R5 flag set on match", 16'(match_flag_o), 16'd1);
    chk(irq_o == 1'b1, "R7 irq raised", 16'(irq_o), 16'd1);
    cyc(16'h0103, 0, 2'd3, 8'h00, 1);
    cyc(16'h0103, 0, 2'd3, 8'h00, 0);
    chk(match_flag_o == 1'b0, "R5 held match sets flag once", 16'(match_flag_o), 16'd0);
    chk(cex_o == 1'b0, "R8 held match toggles once", 16'(cex_o), 16'd0);
    cyc(16'h0104, 0, 2'd3, 8'h00, 0);
    cyc(16'h0103, 0, 2'd3, 8'h00, 1);
    chk(match_flag_o == 1'b1, "R6 set wins over clear", 16'(match_flag_o), 16'd1);
    chk(cex_o == 1'b1, "R8 second match toggles", 16'(cex_o), 16'd1);
    cyc(16'h0105, 0, 2'd3, 8'h00, 0);
    chk(match_flag_o == 1'b1, "R6 flag sticky", 16'(match_flag_o), 16'd1);
    cyc(16'h0105, 0, 2'd3, 8'h00, 1);

    // R11 no toggle bit
    cyc(16'h0105, 1, 2'd0, 8'h18, 0);
    cyc(16'h0103, 0, 2'd3, 8'h00, 0);
    chk(cex_o == 1'b1, "R11 cex holds without toggle", 16'(cex_o), 16'd1);
    chk(match_flag_o == 1'b1, "R5 flag with match bit only", 16'(match_flag_o), 16'd1);
    cyc(16'h0104, 0, 2'd3, 8'h00, 1);

    // R9 / R10 PWM
    cyc(16'h0030, 1, 2'd1, 8'h40, 0);
    cyc(16'h0030, 1, 2'd2, 8'h80, 0);
    cyc(16'h0030, 1, 2'd0, 8'h12, 0);
    chk(mode_o == 5'h12, "R4 mode pwm", 16'(mode_o), 16'h12);
    cnt = 16'h0031;
    while (cnt != 16'h0100) begin
      cyc(cnt, 0, 2'd3, 8'h00, 0);
      if (cnt == 16'h003F) chk(cex_o == 1'b0, "R9 below duty", 16'(cex_o), 16'd0);
      if (cnt == 16'h0040) chk(cex_o == 1'b1, "R9 at duty", 16'(cex_o), 16'd1);
      if (cnt == 16'h0070) chk(cex_o == 1'b1, "R10 old duty before wrap", 16'(cex_o), 16'd1);
      cnt++;
    end
    cnt = 16'h0000;
    while (cnt != 16'h0081) begin
      cyc(cnt, 0, 2'd3, 8'h00, 0);
      if (cnt == 16'h0000) chk(cex_o == 1'b0, "R10 new duty in wrap cycle", 16'(cex_o), 16'd0);
      if (cnt == 16'h0070) chk(cex_o == 1'b0, "R10 new duty after wrap", 16'(cex_o), 16'd0);
      if (cnt == 16'h0080) chk(cex_o == 1'b1, "R10 at new duty", 16'(cex_o), 16'd1);
      cnt++;
    end

    // random phase
    cnt = 16'h1234;
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [1:0] sel;
      logic [7:0] d;
      int r;
      r = int'($urandom_range(0, 31));
      if (r == 0) cnt = 16'($urandom);
      else if (r > 2) cnt++;
      we  = ($urandom_range(0, 7) == 0);
      sel = 2'($urandom);
      d   = 8'($urandom);
      if (sel == 2'd2) d = cnt[15:8];
      if (sel == 2'd1) d = cnt[7:0] + 8'($urandom_range(0, 20));
      cyc(cnt, we, sel, d, ($urandom_range(0, 15) == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule